// File: doc/BRIEF.md
# Spike Bitmap Packet Encoder

This block sits in a leaf router that serves a small group of spiking neurons. Every clock cycle it samples one spike line per neuron. Whenever at least one neuron has fired, it emits a single fixed-width packet toward the parent router, instead of one packet per neuron. The packet carries three things taken from local configuration registers: a header constant, a destination address and the node's own identifier. It also carries a bitmap with one bit for each neuron that fired.

Packets leave through a valid/ready handshake. If the parent stalls, spikes that arrive in the meantime are merged by OR into a pending bitmap. That bitmap goes out in the next packet, so no spike is lost. No packet is formed while the pending bitmap is empty.

Top module: `spk_pkt_encoder`

## Requirements
- R1: While `rst_ni` is low, `pkt_valid_o` is low and the pending bitmap is empty. After release, no packet appears until a spike is sampled.
- R2: The packet is 48 bits wide.
  - Bits [47:44] hold the header.
  - Bits [43:14] hold the target address.
  - Bits [13:10] hold the node identifier.
  - Bits [9:0] hold the firing bitmap, where spike line i maps to bitmap bit i.
- R3: Spikes sampled on several lines in the same cycle are reported together in one packet.
- R4: A spike sampled at clock edge k appears on the output after edge k+1, provided the output register is empty or accepted at edge k+1. Back-to-back packets are possible.
- R5: `pkt_valid_o` is never high with an all-zero bitmap field.
- R6: While `pkt_valid_o` is high and `pkt_ready_i` is low, `pkt_valid_o` and `pkt_data_o` stay unchanged on the next cycle.
- R7: Spikes sampled while the output is stalled are ORed into the pending bitmap and sent in the packet that follows acceptance. No spike is dropped.
- R8: A configuration write takes effect for packets loaded after the write edge. A packet already held on the output keeps the values it was built with.
- R9: When a packet is accepted and nothing is pending, `pkt_valid_o` is low after that edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| spike_i | input | 10 | One spike line per neuron, sampled every cycle |
| cfg_we_i | input | 1 | Loads all three configuration fields |
| cfg_hdr_i | input | 4 | Header constant to store |
| cfg_tgt_i | input | 30 | Destination address to store |
| cfg_node_i | input | 4 | Node identifier to store |
| pkt_valid_o | output | 1 | Packet on `pkt_data_o` is valid |
| pkt_ready_i | input | 1 | Parent accepts the packet |
| pkt_data_o | output | 48 | Assembled packet |

## Verification
The assertions check four rules on every cycle:
- a valid packet never carries an empty bitmap;
- a stalled packet holds its valid and data;
- every sampled spike lands in the pending bitmap;
- a non-empty pending bitmap reaches a free output on the next edge.

Only the bench scenarios can show the rest:
- the exact bit placement of fields;
- that merged spikes come out in the right packet after a stall;
- that a configuration change leaves a held packet alone and reaches the next one;
- that reset discards pending spikes.

// File: rtl/spk_enc_pkg.sv
package spk_enc_pkg;
  localparam int unsigned DEF_N_NEURON = 10;
  localparam int unsigned DEF_HDR_W    = 4;
  localparam int unsigned DEF_TGT_W    = 30;
  localparam int unsigned DEF_NODE_W   = 4;

  typedef enum logic {
    OUT_IDLE = 1'b0,
    OUT_HOLD = 1'b1
  } out_state_e;
endpackage

// File: rtl/spk_cfg_regs.sv
module spk_cfg_regs #(
  parameter int unsigned HDR_W  = 4,
  parameter int unsigned TGT_W  = 30,
  parameter int unsigned NODE_W = 4,
  parameter logic [HDR_W-1:0] HDR_RST = '1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [HDR_W-1:0]  hdr_i,
  input  logic [TGT_W-1:0]  tgt_i,
  input  logic [NODE_W-1:0] node_i,
  output logic [HDR_W-1:0]  hdr_o,
  output logic [TGT_W-1:0]  tgt_o,
  output logic [NODE_W-1:0] node_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hdr_o  <= HDR_RST;
      tgt_o  <= '0;
      node_o <= '0;
    end else if (we_i) begin
      hdr_o  <= hdr_i;
      tgt_o  <= tgt_i;
      node_o <= node_i;
    end
  end
endmodule

// File: rtl/spk_capture.sv
module spk_capture #(
  parameter int unsigned N_NEURON = 10
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [N_NEURON-1:0] spike_i,
  input  logic                take_i,
  output logic [N_NEURON-1:0] pend_o,
  output logic                pend_nz_o
);
  logic [N_NEURON-1:0] pend_d;

  // take_i empties the bitmap into the output stage; same-cycle spikes still land
  for (genvar i = 0; i < N_NEURON; i++) begin : g_bit
    assign pend_d[i] = (pend_o[i] & ~take_i) | spike_i[i];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pend_o <= '0;
    else         pend_o <= pend_d;
  end

  assign pend_nz_o = |pend_o;
endmodule

// File: rtl/spk_pkt_fmt.sv
module spk_pkt_fmt #(
  parameter int unsigned N_NEURON = 10,
  parameter int unsigned HDR_W    = 4,
  parameter int unsigned TGT_W    = 30,
  parameter int unsigned NODE_W   = 4,
  localparam int unsigned PKT_W   = HDR_W + TGT_W + NODE_W + N_NEURON
) (
  input  logic [HDR_W-1:0]    hdr_i,
  input  logic [TGT_W-1:0]    tgt_i,
  input  logic [NODE_W-1:0]   node_i,
  input  logic [N_NEURON-1:0] map_i,
  output logic [PKT_W-1:0]    pkt_o
);
  localparam int unsigned NODE_LSB = N_NEURON;
  localparam int unsigned TGT_LSB  = NODE_LSB + NODE_W;
  localparam int unsigned HDR_LSB  = TGT_LSB + TGT_W;

  assign pkt_o[HDR_LSB  +: HDR_W]  = hdr_i;
  assign pkt_o[TGT_LSB  +: TGT_W]  = tgt_i;
  assign pkt_o[NODE_LSB +: NODE_W] = node_i;
  assign pkt_o[0 +: N_NEURON]      = map_i;
endmodule

// File: rtl/spk_out_stage.sv
module spk_out_stage
  import spk_enc_pkg::*;
#(
  parameter int unsigned PKT_W = 48
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             pend_nz_i,
  input  logic [PKT_W-1:0] pkt_i,
  input  logic             ready_i,
  output logic             take_o,
  output logic             valid_o,
  output logic [PKT_W-1:0] data_o
);
  out_state_e state_q, state_d;
  logic       free;

  assign free   = (state_q == OUT_IDLE) || ready_i;
  assign take_o = free && pend_nz_i;

  always_comb begin
    state_d = state_q;
    if (take_o)    state_d = OUT_HOLD;
    else if (free) state_d = OUT_IDLE;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= OUT_IDLE;
      data_o  <= '0;
    end else begin
      state_q <= state_d;
      if (take_o) data_o <= pkt_i;
    end
  end

  assign valid_o = (state_q == OUT_HOLD);
endmodule

// File: rtl/spk_pkt_encoder.sv
module spk_pkt_encoder
  import spk_enc_pkg::*;
#(
  parameter int unsigned N_NEURON = DEF_N_NEURON,
  parameter int unsigned HDR_W    = DEF_HDR_W,
  parameter int unsigned TGT_W    = DEF_TGT_W,
  parameter int unsigned NODE_W   = DEF_NODE_W,
  parameter logic [HDR_W-1:0] HDR_RST = '1,
  localparam int unsigned PKT_W   = HDR_W + TGT_W + NODE_W + N_NEURON
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [N_NEURON-1:0] spike_i,
  input  logic                cfg_we_i,
  input  logic [HDR_W-1:0]    cfg_hdr_i,
  input  logic [TGT_W-1:0]    cfg_tgt_i,
  input  logic [NODE_W-1:0]   cfg_node_i,
  output logic                pkt_valid_o,
  input  logic                pkt_ready_i,
  output logic [PKT_W-1:0]    pkt_data_o
);
  logic [HDR_W-1:0]    hdr_q;
  logic [TGT_W-1:0]    tgt_q;
  logic [NODE_W-1:0]   node_q;
  logic [N_NEURON-1:0] pend_q;
  logic                pend_nz;
  logic                take;
  logic [PKT_W-1:0]    pkt_next;

  spk_cfg_regs #(
    .HDR_W(HDR_W), .TGT_W(TGT_W), .NODE_W(NODE_W), .HDR_RST(HDR_RST)
  ) i_cfg (
    .clk_i, .rst_ni,
    .we_i(cfg_we_i), .hdr_i(cfg_hdr_i), .tgt_i(cfg_tgt_i), .node_i(cfg_node_i),
    .hdr_o(hdr_q), .tgt_o(tgt_q), .node_o(node_q)
  );

  spk_capture #(.N_NEURON(N_NEURON)) i_cap (
    .clk_i, .rst_ni,
    .spike_i, .take_i(take),
    .pend_o(pend_q), .pend_nz_o(pend_nz)
  );

  spk_pkt_fmt #(
    .N_NEURON(N_NEURON), .HDR_W(HDR_W), .TGT_W(TGT_W), .NODE_W(NODE_W)
  ) i_fmt (
    .hdr_i(hdr_q), .tgt_i(tgt_q), .node_i(node_q), .map_i(pend_q),
    .pkt_o(pkt_next)
  );

  spk_out_stage #(.PKT_W(PKT_W)) i_out (
    .clk_i, .rst_ni,
    .pend_nz_i(pend_nz), .pkt_i(pkt_next), .ready_i(pkt_ready_i),
    .take_o(take), .valid_o(pkt_valid_o), .data_o(pkt_data_o)
  );
endmodule

// File: rtl/spk_enc_chk.sv
module spk_enc_chk #(
  parameter int unsigned N_NEURON = 10,
  parameter int unsigned PKT_W    = 48
) (
  input logic                clk_i,
  input logic                rst_ni,
  input logic [N_NEURON-1:0] spike_i,
  input logic [N_NEURON-1:0] pend_i,
  input logic                pkt_ready_i,
  input logic                pkt_valid_o,
  input logic [PKT_W-1:0]    pkt_data_o
);
  AST_NO_EMPTY_PKT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pkt_valid_o |-> (pkt_data_o[N_NEURON-1:0] != '0)); // R5

  AST_STALL_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pkt_valid_o && !pkt_ready_i) |=> (pkt_valid_o && $stable(pkt_data_o))); // R6

  AST_SPIKE_KEPT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (spike_i != '0) |=> ((pend_i & $past(spike_i)) == $past(spike_i))); // R7

  AST_PEND_ISSUED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((pend_i != '0) && (!pkt_valid_o || pkt_ready_i)) |=> pkt_valid_o); // R4
endmodule

bind spk_pkt_encoder spk_enc_chk #(.N_NEURON(N_NEURON), .PKT_W(PKT_W)) i_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .spike_i(spike_i), .pend_i(pend_q),
  .pkt_ready_i(pkt_ready_i), .pkt_valid_o(pkt_valid_o), .pkt_data_o(pkt_data_o)
);

// File: tb/test_spk_pkt_encoder.sv
module test_spk_pkt_encoder;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic [9:0]  spike = '0;
  logic        cfg_we = 1'b0;
  logic [3:0]  cfg_hdr = '0;
  logic [29:0] cfg_tgt = '0;
  logic [3:0]  cfg_node = '0;
  logic        valid;
  logic        ready = 1'b0;
  logic [47:0] data;
  int          n_run = 0;
  int          n_fail = 0;

  always #2 clk = ~clk;

  spk_pkt_encoder i_spk_pkt_encoder (
    .clk_i(clk), .rst_ni(rst_ni), .spike_i(spike),
    .cfg_we_i(cfg_we), .cfg_hdr_i(cfg_hdr), .cfg_tgt_i(cfg_tgt), .cfg_node_i(cfg_node),
    .pkt_valid_o(valid), .pkt_ready_i(ready), .pkt_data_o(data)
  );

  // {spike[9:0], ready, exp_valid, exp_map[9:0]}
  localparam logic [21:0] VEC [15] = '{
    {10'h000, 1'b1, 1'b0, 10'h000},
    {10'h120, 1'b1, 1'b0, 10'h000},
    {10'h000, 1'b1, 1'b1, 10'h120},
    {10'h000, 1'b1, 1'b0, 10'h000},
    {10'h001, 1'b0, 1'b0, 10'h000},
    {10'h200, 1'b0, 1'b1, 10'h001},
    {10'h010, 1'b0, 1'b1, 10'h001},
    {10'h002, 1'b0, 1'b1, 10'h001},
    {10'h000, 1'b1, 1'b1, 10'h212},
    {10'h3FF, 1'b1, 1'b0, 10'h000},
    {10'h000, 1'b0, 1'b1, 10'h3FF},
    {10'h004, 1'b1, 1'b0, 10'h000},
    {10'h008, 1'b1, 1'b1, 10'h004},
    {10'h000, 1'b1, 1'b1, 10'h008},
    {10'h000, 1'b1, 1'b0, 10'h000}
  };

  task automatic check(input logic ok, input string req, input logic [47:0] act, input logic [47:0] exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic step(input logic [9:0] s, input logic r);
    @(negedge clk);
    spike = s;
    ready = r;
    @(posedge clk);
    #1;
  endtask

  task automatic write_cfg(input logic [3:0] h, input logic [29:0] t, input logic [3:0] n);
    @(negedge clk);
    cfg_we = 1'b1; cfg_hdr = h; cfg_tgt = t; cfg_node = n;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  initial begin
    logic [47:0] held;
    repeat (3) @(negedge clk);
    // R1: reset state
    check(valid == 1'b0, "R1 reset valid", {47'b0, valid}, 48'h0);
    rst_ni = 1'b1;
    write_cfg(4'hF, 30'h0202_01C1, 4'h1);
    check(valid == 1'b0, "R1 idle after release", {47'b0, valid}, 48'h0);

    // R3 R4 R5 R6 R7 R9: vector walk
    for (int i = 0; i < 15; i++) begin
      step(VEC[i][21:12], VEC[i][11]);
      check(valid == VEC[i][10], $sformatf("R4/R6/R9 vec%0d valid", i), {47'b0, valid}, {47'b0, VEC[i][10]});
      if (VEC[i][10]) begin
        check(data[9:0] == VEC[i][9:0], $sformatf("R3/R7 vec%0d map", i), data, {38'b0, VEC[i][9:0]});
        // R2: field layout
        check(data[47:10] == {4'hF, 30'h0202_01C1, 4'h1}, $sformatf("R2 vec%0d fields", i),
              data, {4'hF, 30'h0202_01C1, 4'h1, VEC[i][9:0]});
      end
    end

    // R8: config change while a packet is held
    step(10'h040, 1'b0);
    step(10'h000, 1'b0);
    held = data;
    check(valid && held == {4'hF, 30'h0202_01C1, 4'h1, 10'h040}, "R8 held old cfg", held,
          {4'hF, 30'h0202_01C1, 4'h1, 10'h040});
    @(negedge clk);
    cfg_we = 1'b1; cfg_hdr = 4'hA; cfg_tgt = 30'h1234_5678; cfg_node = 4'h7; spike = 10'h080;
    @(posedge clk); #1;
    cfg_we = 1'b0;
    check(valid && data == held, "R8 held unchanged after write", data, held);
    step(10'h000, 1'b1);
    check(valid && data == {4'hA, 30'h1234_5678, 4'h7, 10'h080}, "R8 new cfg used", data,
          {4'hA, 30'h1234_5678, 4'h7, 10'h080});
    step(10'h000, 1'b1);
    check(valid == 1'b0, "R9 drop after accept", {47'b0, valid}, 48'h0);

    // R1: reset discards pending and held
    step(10'h00F, 1'b0);
    step(10'h030, 1'b0);
    @(negedge clk);
    spike = '0;
    rst_ni = 1'b0;
    #1;
    check(valid == 1'b0, "R1 async clear", {47'b0, valid}, 48'h0);
    @(negedge clk);
    rst_ni = 1'b1;
    ready = 1'b1;
    repeat (3) begin
      @(posedge clk); #1;
      check(valid == 1'b0, "R1 pending cleared", {47'b0, valid}, 48'h0);
    end

    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    n_run++;
    n_fail++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule